// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the command front end of a parallel NOR flash device model, limited to the whole-array erase path. It samples the asynchronous bus strobes (chip enable, write enable, output enable) in its own clock domain. A bus write takes effect when write enable rises while chip enable is low. The block tracks the unlock-and-confirm write pattern that starts an erase, and the address it expects in that pattern depends on whether the device is configured for 8-bit or 16-bit access. Once the erase starts, a parameterised cycle counter stands in for the erase time. It tells the array stub first to force every location to zero and then to erase it.

Reads made while the erase runs return a status byte in place of array data. Two bits of that byte flip after every completed status read, so host software can poll for completion. If the stub reports a failure at the end of the erase, the block stays in a failed status state until the host writes a reset command. A suspend command pauses the erase and a resume command continues it. Any write that breaks the unlock pattern drops the block back to plain array reads without raising an error.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is in array-read mode: `rd_data` equals `array_rdata` and `array_op` is 0 (idle).
- R2: A write is taken only when `we_n` rises while `ce_n` is low. A write strobe with `ce_n` high has no effect, and an unlock pattern interrupted by such a strobe still completes.
- R3: The erase starts after six accepted writes in this order: AAh at the first unlock address, 55h at the second, 80h at the first, AAh at the first, 55h at the second, 10h at the first. The unlock addresses in the low 12 address bits are AAAh and 555h when `byte_mode` is 1, and 555h and 2AAh when it is 0.
- R4: If any of the six writes has the wrong data or the wrong address, the block returns silently to array-read mode: no erase starts and reads return `array_rdata`.
- R5: While the erase runs, `rd_data` is a status byte. Bit 7 (poll) is 0, bit 5 (failure) is 0, bits 6 and 2 carry the toggle value, and bits 4, 3, 1 and 0 are 0.
- R6: Each status read that completes during the erase (`oe_n` rising while `ce_n` is low) inverts bits 6 and 2 for the next read.
- R7: A running erase lasts ERASE_CYCLES clock cycles. `array_op` is 1 (fill with 00h) for the first ERASE_CYCLES/2 cycles and 2 (erase to FFh) for the rest, and it never goes from 2 back to 1 within one erase.
- R8: When the erase ends and `erase_fail` is low, the block returns to array-read mode and `array_op` becomes 0.
- R9: When the erase ends and `erase_fail` is high, reads return a status byte with bits 7 and 5 set. Bits 6 and 2 hold steady across reads. The block stays in this state until F0h is written.
- R10: While the erase runs, every write other than B0h and F0h is ignored. The erase keeps running and the status reads continue.
- R11: A write of F0h at any address returns the block to array-read mode from a partial unlock pattern, from a running or suspended erase, or from the failed state.
- R12: B0h written during the erase suspends it: `array_op` is 0, reads return `array_rdata`, and the cycle counter holds its value. 30h written while suspended resumes the erase, and only the remaining cycles are run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable; a rising edge commits a write |
| oe_n | input | 1 | Output enable; a rising edge ends a read |
| byte_mode | input | 1 | 1 selects 8-bit unlock addresses, 0 selects 16-bit |
| addr | input | ADDR_W | Bus address; the low 12 bits are decoded |
| wdata | input | 8 | Command byte |
| array_rdata | input | 8 | Data from the array stub |
| erase_fail | input | 1 | Stub result, sampled on the last erase cycle |
| rd_data | output | 8 | Array data or status byte |
| array_op | output | 2 | Command to the stub: 0 idle, 1 fill with 00h, 2 erase to FFh |

## Verification
The assertions assume that the strobes change only when the address and data are stable, that each strobe is held for at least one clock so that every edge is sampled, and that `erase_fail` is steady around the last erase cycle. The bench drives every bus cycle through tasks that set up the address and data a full clock before a strobe moves and hold each level for a clock. It also keeps the stub's failure flag fixed for the whole of an erase. Random command patterns, corruptions and ignored writes are packed into a window much shorter than the erase, so that no status read overlaps the end of the erase.

// File: rtl/fes_pkg.sv
package fes_pkg;
    typedef enum logic [3:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_SETUP,
        ST_UL4,
        ST_UL5,
        ST_BUSY,
        ST_SUSP,
        ST_FAIL
    } fes_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ZERO  = 2'd1,
        OP_ERASE = 2'd2
    } fes_op_e;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'h10;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;

    localparam int DEC_W = 12;
    localparam logic [DEC_W-1:0] BYTE_A1 = 12'hAAA;
    localparam logic [DEC_W-1:0] BYTE_A2 = 12'h555;
    localparam logic [DEC_W-1:0] WORD_A1 = 12'h555;
    localparam logic [DEC_W-1:0] WORD_A2 = 12'h2AA;
endpackage

// File: rtl/fes_bus_sense.sv
module fes_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_evt,
    output logic rd_evt
);
    typedef struct packed {
        logic we;
        logic oe;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d.we = we_n;
        s_d.oe = oe_n;
        wr_evt = ~ce_n & we_n & ~s_q.we;
        rd_evt = ~ce_n & oe_n & ~s_q.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{we: 1'b1, oe: 1'b1};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
    import fes_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              byte_mode,
    output logic              hit_key1,
    output logic              hit_key2,
    output logic              hit_setup,
    output logic              hit_confirm,
    output logic              hit_reset,
    output logic              hit_suspend,
    output logic              hit_resume
);
    logic [DEC_W-1:0] low_a;
    logic [DEC_W-1:0] a1;
    logic [DEC_W-1:0] a2;

    always_comb begin
        low_a       = addr[DEC_W-1:0];
        a1          = byte_mode ? BYTE_A1 : WORD_A1;
        a2          = byte_mode ? BYTE_A2 : WORD_A2;
        hit_key1    = (wdata == CMD_KEY1)    && (low_a == a1);
        hit_key2    = (wdata == CMD_KEY2)    && (low_a == a2);
        hit_setup   = (wdata == CMD_SETUP)   && (low_a == a1);
        hit_confirm = (wdata == CMD_CONFIRM) && (low_a == a1);
        hit_reset   = (wdata == CMD_RESET);
        hit_suspend = (wdata == CMD_SUSPEND);
        hit_resume  = (wdata == CMD_RESUME);
    end
endmodule

// File: rtl/fes_erase_timer.sv
module fes_erase_timer #(
    parameter int CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic done,
    output logic in_erase
);
    localparam int CNT_W = $clog2(CYCLES);
    localparam int HALF  = CYCLES / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        done     = run && (t_q.cnt == CNT_W'(CYCLES - 1));
        in_erase = (t_q.cnt >= CNT_W'(HALF));
        if (run)       t_d.cnt = done ? '0 : t_q.cnt + 1'b1;
        else if (!hold) t_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt < CNT_W'(CYCLES));
    // R12
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !run) |=> (t_q.cnt == $past(t_q.cnt)));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int ERASE_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        array_rdata,
    input  logic              erase_fail,
    output logic [7:0]        rd_data,
    output logic [1:0]        array_op
);
    typedef struct packed {
        fes_state_e st;
        logic       tog;
    } seq_t;

    seq_t r_d, r_q;
    logic wr_evt, rd_evt;
    logic hit_key1, hit_key2, hit_setup, hit_confirm;
    logic hit_reset, hit_suspend, hit_resume;
    logic t_done, t_in_erase;

    fes_bus_sense u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt)
    );

    fes_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr        (addr),
        .wdata       (wdata),
        .byte_mode   (byte_mode),
        .hit_key1    (hit_key1),
        .hit_key2    (hit_key2),
        .hit_setup   (hit_setup),
        .hit_confirm (hit_confirm),
        .hit_reset   (hit_reset),
        .hit_suspend (hit_suspend),
        .hit_resume  (hit_resume)
    );

    fes_erase_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.st == ST_BUSY),
        .hold     (r_q.st == ST_SUSP),
        .done     (t_done),
        .in_erase (t_in_erase)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_READ:  if (wr_evt && hit_key1) r_d.st = ST_UL1;
            ST_UL1:   if (wr_evt) r_d.st = hit_key2    ? ST_UL2   : ST_READ;
            ST_UL2:   if (wr_evt) r_d.st = hit_setup   ? ST_SETUP : ST_READ;
            ST_SETUP: if (wr_evt) r_d.st = hit_key1    ? ST_UL4   : ST_READ;
            ST_UL4:   if (wr_evt) r_d.st = hit_key2    ? ST_UL5   : ST_READ;
            ST_UL5:   if (wr_evt) r_d.st = hit_confirm ? ST_BUSY  : ST_READ;
            ST_BUSY: begin
                if (t_done)                    r_d.st = erase_fail ? ST_FAIL : ST_READ;
                else if (wr_evt && hit_reset)  r_d.st = ST_READ;
                else if (wr_evt && hit_suspend) r_d.st = ST_SUSP;
                if (rd_evt) r_d.tog = ~r_q.tog;
            end
            ST_SUSP: begin
                if (wr_evt && hit_reset)       r_d.st = ST_READ;
                else if (wr_evt && hit_resume) r_d.st = ST_BUSY;
            end
            ST_FAIL:  if (wr_evt && hit_reset) r_d.st = ST_READ;
            default:  r_d.st = ST_READ;
        endcase

        case (r_q.st)
            ST_BUSY: rd_data = {1'b0, r_q.tog, 1'b0, 2'b00, r_q.tog, 2'b00};
            ST_FAIL: rd_data = {1'b1, r_q.tog, 1'b1, 2'b00, r_q.tog, 2'b00};
            default: rd_data = array_rdata;
        endcase

        if (r_q.st == ST_BUSY) array_op = t_in_erase ? OP_ERASE : OP_ZERO;
        else                   array_op = OP_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_READ, tog: 1'b0};
        else        r_q <= r_d;
    end

    // R6
    status_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && rd_evt) |=> (r_q.tog != $past(r_q.tog)));
    // R7
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (array_op == OP_ERASE) |=> (array_op != OP_ZERO));
    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FAIL && !(wr_evt && hit_reset)) |=> (r_q.st == ST_FAIL && $stable(r_q.tog)));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && wr_evt && !hit_reset && !hit_suspend && !t_done) |=> (r_q.st == ST_BUSY));
    // R12
    susp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SUSP) |-> (array_op == OP_NONE && rd_data == array_rdata));
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
    localparam int N  = 200;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, array_rdata = 8'h3C;
    logic erase_fail = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] array_op;

    int tests = 0, fails = 0;
    int zero_cyc = 0, erase_cyc = 0;
    logic exp_tog = 1'b0;

    always #4 clk = ~clk;

    flash_erase_seq #(.ADDR_W(AW), .ERASE_CYCLES(N)) u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .addr(addr), .wdata(wdata),
        .array_rdata(array_rdata), .erase_fail(erase_fail),
        .rd_data(rd_data), .array_op(array_op)
    );

    always @(negedge clk) begin
        if (array_op == 2'd1) zero_cyc = zero_cyc + 1;
        if (array_op == 2'd2) erase_cyc = erase_cyc + 1;
    end

    function automatic logic [7:0] status_byte(input logic poll, input logic tg, input logic fl);
        return {poll, tg, fl, 2'b00, tg, 2'b00};
    endfunction

    function automatic logic [11:0] unlock_addr(input logic bm, input int which);
        if (which == 1) return bm ? 12'hAAA : 12'h555;
        return bm ? 12'h555 : 12'h2AA;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        addr = {{(AW-12){1'b0}}, a};
        wdata = d;
        ce_n = ~sel;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic bus_read(output logic [7:0] v);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk); v = rd_data; oe_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic seq_step(input logic bm, input int i, output logic [11:0] a, output logic [7:0] d);
        case (i)
            1, 4: begin a = unlock_addr(bm, 1); d = 8'hAA; end
            2, 5: begin a = unlock_addr(bm, 2); d = 8'h55; end
            3:    begin a = unlock_addr(bm, 1); d = 8'h80; end
            default: begin a = unlock_addr(bm, 1); d = 8'h10; end
        endcase
    endtask

    task automatic start_erase(input logic bm);
        logic [11:0] a;
        logic [7:0] d;
        byte_mode = bm;
        for (int i = 1; i <= 6; i++) begin
            seq_step(bm, i, a, d);
            bus_write(a, d, 1'b1);
        end
        zero_cyc = 0;
        erase_cyc = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4 * N && array_op != 2'd0; k++) @(negedge clk);
    endtask

    task automatic busy_read(input string req);
        logic [7:0] v;
        bus_read(v);
        check(v == status_byte(1'b0, exp_tog, 1'b0), req, v, status_byte(1'b0, exp_tog, 1'b0));
        exp_tog = ~exp_tog;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        logic [11:0] a;
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rd_data == array_rdata, "R1 rd_data", rd_data, array_rdata);
        check(array_op == 2'd0, "R1 array_op", array_op, 0);

        // R2 write with ce_n high is ignored mid-pattern; pattern still completes
        byte_mode = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            seq_step(1'b1, i, a, d);
            if (i == 3) bus_write(12'h123, 8'h00, 1'b0);
            bus_write(a, d, 1'b1);
        end
        zero_cyc = 0; erase_cyc = 0;
        @(negedge clk);
        check(array_op == 2'd1, "R2 erase started", array_op, 1);
        // R11 reset during busy
        bus_write(12'h777, 8'hF0, 1'b1);
        check(array_op == 2'd0, "R11 abort op", array_op, 0);
        bus_read(v);
        check(v == array_rdata, "R11 abort read", v, array_rdata);

        // R11 reset from partial pattern, then fresh full pattern (word mode)
        byte_mode = 1'b0;
        bus_write(12'h555, 8'hAA, 1'b1);
        bus_write(12'h2AA, 8'h55, 1'b1);
        bus_write(12'h001, 8'hF0, 1'b1);
        bus_read(v);
        check(v == array_rdata, "R11 partial reset", v, array_rdata);

        // R12 suspend and resume
        erase_fail = 1'b0;
        start_erase(1'b0);
        repeat (30) @(negedge clk);
        bus_write(12'h000, 8'hB0, 1'b1);
        check(array_op == 2'd0, "R12 suspended op", array_op, 0);
        array_rdata = 8'h5A;
        bus_read(v);
        check(v == 8'h5A, "R12 suspended read", v, 8'h5A);
        repeat (40) @(negedge clk);
        check(array_op == 2'd0, "R12 still suspended", array_op, 0);
        bus_write(12'h000, 8'h30, 1'b1);
        check(array_op != 2'd0, "R12 resumed", array_op, 1);
        wait_idle();
        check(zero_cyc == N / 2, "R12 R7 fill cycles", zero_cyc, N / 2);
        check(erase_cyc == N - N / 2, "R12 R7 erase cycles", erase_cyc, N - N / 2);

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic bm;
            int corrupt;
            bm = 1'($urandom % 2);
            byte_mode = bm;
            array_rdata = 8'($urandom);
            erase_fail = 1'($urandom % 2);
            corrupt = ($urandom % 3 == 0) ? 1 + int'($urandom % 6) : 0;
            if (corrupt != 0) begin
                for (int i = 1; i <= corrupt; i++) begin
                    seq_step(bm, i, a, d);
                    if (i == corrupt) begin
                        if ($urandom % 2 == 1) d = 8'h12;
                        else a = a ^ 12'h001;
                    end
                    bus_write(a, d, 1'b1);
                end
                bus_read(v);
                check(v == array_rdata, "R4 abort read", v, array_rdata);
                check(array_op == 2'd0, "R4 abort op", array_op, 0);
            end else begin
                start_erase(bm);
                // R3 erase running in chosen mode
                check(array_op == 2'd1, "R3 erase started", array_op, 1);
                for (int r = 0; r < 1 + int'($urandom % 3); r++) begin
                    busy_read("R5 R6 status read");
                    case ($urandom % 4)
                        0: d = 8'hAA;
                        1: d = 8'h55;
                        2: d = 8'h10;
                        default: d = 8'h80;
                    endcase
                    bus_write(unlock_addr(bm, 1), d, 1'b1);
                    // R10 ignored write: still busy
                    check(array_op != 2'd0, "R10 busy after write", array_op, 1);
                end
                busy_read("R10 status after ignored writes");
                wait_idle();
                check(zero_cyc == N / 2, "R7 fill cycles", zero_cyc, N / 2);
                check(erase_cyc == N - N / 2, "R7 erase cycles", erase_cyc, N - N / 2);
                bus_read(v);
                if (erase_fail) begin
                    check(v == status_byte(1'b1, exp_tog, 1'b1), "R9 fail status", v, status_byte(1'b1, exp_tog, 1'b1));
                    bus_write(unlock_addr(bm, 1), 8'hAA, 1'b1);
                    bus_read(v2);
                    check(v2 == v, "R9 steady", v2, v);
                    bus_write(12'($urandom), 8'hF0, 1'b1);
                    bus_read(v);
                    check(v == array_rdata, "R11 reset from fail", v, array_rdata);
                end else begin
                    check(v == array_rdata, "R8 done read", v, array_rdata);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule